// File: doc/BRIEF.md
# Programmable Serial Peripheral Master

This block drives one SPI slave from a fast system clock. On a start pulse it asserts its single chip select, waits a programmable lead-in, then emits a burst of serial-clock pulses. During the burst it shifts one character out on the data-out line and captures one character from the data-in line. After the last pulse it holds chip select for half a serial-clock period, releases it, and flags completion.

The host picks several settings per transfer:
- the idle level of the serial clock and the edge on which data is captured, which together cover the four standard SPI modes;
- a character length from 1 to 32 bits;
- the active level of chip select;
- a lead-in of 0 to 3 extra serial-clock periods;
- a divider that sets the serial-clock rate.

All of these are captured when the start pulse is accepted. Changes to the inputs during a transfer have no effect on it.

Top module: `spi_master_ctrl`

## Requirements
- R1: When no transfer is running, `sclk_o` rests at the level of `cpol_i` (registered one cycle), so `cpol_i`=1 gives a high idle clock. The clock toggles only while a transfer is running, and it is back at that level when the transfer ends.
- R2: The leading edge of a pulse is its first edge away from the idle level. With `cpha_i`=0, data is captured on leading edges and `mosi_o` changes on trailing edges, with the first bit already driven when chip select asserts. With `cpha_i`=1, data changes on leading edges and is captured on trailing edges.
- R3: A transfer moves `len_m1_i`+1 bits and produces exactly that many clock pulses (twice as many edges). The bits sent are `tx_data_i[len-1:0]`, most significant first. Bits of `tx_data_i` above the length are never sent.
- R4: The received bits appear right-aligned in `rx_data_o`, first received bit most significant, with all bits above the length cleared.
- R5: With `cs_pol_i`=0 chip select is active low; with 1 it is active high. `cs_o` sits at the active level for the whole time `busy_o` is high. The reset value of `cs_o` is 1.
- R6: From chip-select assertion to the first clock edge there are (2·D+1)·(N+1) system clocks. D is `dly_i` (0..3).
- R7: Every half period of the serial clock lasts N+1 system clocks. N is `div_i`, with values below 1 treated as 1, so the period is never shorter than 4 system clocks.
- R8: Chip select is released N+1 system clocks after the last clock edge. `done_o` is high for exactly that one cycle, `busy_o` is already low in it, and `rx_data_o` holds the result in it.
- R9: A start pulse while `busy_o` is high is ignored. The running transfer continues unchanged and completes once.
- R10: All settings and `tx_data_i` are captured at the accepted start. Changing them during a transfer does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when idle |
| cpol_i | input | 1 | Serial-clock idle level |
| cpha_i | input | 1 | Capture on trailing edge when 1 |
| cs_pol_i | input | 1 | Chip-select active level |
| div_i | input | DIV_W | Half-period count minus one |
| len_m1_i | input | $clog2(MAX_LEN) | Character length minus one |
| dly_i | input | DLY_W | Extra lead-in periods |
| tx_data_i | input | MAX_LEN | Word to send |
| miso_i | input | 1 | Serial data in |
| busy_o | output | 1 | Transfer running |
| done_o | output | 1 | One-cycle completion pulse |
| rx_data_o | output | MAX_LEN | Received word, right-aligned |
| sclk_o | output | 1 | Serial clock |
| cs_o | output | 1 | Chip select |
| mosi_o | output | 1 | Serial data out |

## Verification
The assertions check several rules on every cycle:
- the chip-select level is held while busy;
- done is a single-cycle pulse that coincides with release and the fall of busy;
- the captured settings stay frozen for the whole transfer;
- no serial-clock level lasts less than two system clocks.

Some behaviour only the bench scenarios can show. This covers the bit order and data on both lines in each of the four modes, and the exact pulse count for lengths of 1, 5, 8, 12, 16, 31 and 32. It also covers the lead-in and trailing times for each delay and divider value, including the clamp of a zero divider. The immunity to a second start and to input changes during a transfer is shown the same way.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL
  } seq_state_e;

  // capture edge when leading xor phase
  function automatic logic is_capture_edge(input logic leading, input logic cpha);
    return leading ^ cpha;
  endfunction
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_m1_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == half_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [MAX_LEN-1:0] tx_i,
  input  logic [LEN_W-1:0]   len_m1_i,
  input  logic               shift_i,
  input  logic               sample_i,
  input  logic               miso_i,
  output logic               mosi_o,
  output logic [MAX_LEN-1:0] rx_o
);
  logic [MAX_LEN-1:0] tx_sr_q;
  logic [MAX_LEN-1:0] rx_sr_q;
  logic [LEN_W-1:0]   pad;

  // left-align so the first bit sits at the top
  assign pad    = LEN_W'(MAX_LEN - 1) - len_m1_i;
  assign mosi_o = tx_sr_q[MAX_LEN-1];
  assign rx_o   = rx_sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tx_sr_q <= '0;
    else if (load_i)  tx_sr_q <= tx_i << pad;
    else if (shift_i) tx_sr_q <= {tx_sr_q[MAX_LEN-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_sr_q <= '0;
    else if (load_i)   rx_sr_q <= '0;
    else if (sample_i) rx_sr_q <= {rx_sr_q[MAX_LEN-2:0], miso_i};
  end
endmodule

// File: rtl/spi_seq_fsm.sv
module spi_seq_fsm
  import spi_master_pkg::*;
#(
  parameter int LEN_W = 5,
  parameter int DLY_W = 2,
  localparam int EDGE_W = LEN_W + 1,
  localparam int LEAD_W = DLY_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             cpol_live_i,
  input  logic             cs_pol_live_i,
  input  logic [DLY_W-1:0] dly_live_i,
  input  logic             cpha_q_i,
  input  logic             cs_pol_q_i,
  input  logic [LEN_W-1:0] len_m1_q_i,
  output logic             busy_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             sample_o,
  output logic             finish_o,
  output logic             done_o,
  output logic             sclk_o,
  output logic             cs_o
);
  seq_state_e        state_q;
  logic [LEAD_W-1:0] lead_q;
  logic [EDGE_W-1:0] edge_q;
  logic              sclk_q, cs_q, done_q;
  logic              edge_go, last_edge, leading, capture;

  assign busy_o    = (state_q != ST_IDLE);
  assign load_o    = start_i && (state_q == ST_IDLE);
  assign edge_go   = tick_i && (((state_q == ST_LEAD) && (lead_q == '0)) || (state_q == ST_SHIFT));
  assign last_edge = (edge_q == {len_m1_q_i, 1'b1});
  assign leading   = ~edge_q[0];
  assign capture   = is_capture_edge(leading, cpha_q_i);
  assign sample_o  = edge_go && capture;
  // first data bit is preloaded, so the phase-1 leading edge 0 does not shift
  assign shift_o   = edge_go && !capture && (edge_q != '0);
  assign finish_o  = tick_i && (state_q == ST_TRAIL);
  assign done_o    = done_q;
  assign sclk_o    = sclk_q;
  assign cs_o      = cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lead_q  <= '0;
      edge_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_LEAD;
          lead_q  <= {dly_live_i, 1'b0};
          edge_q  <= '0;
        end
        ST_LEAD: if (tick_i) begin
          if (lead_q == '0) begin
            state_q <= ST_SHIFT;
            edge_q  <= edge_q + EDGE_W'(1);
          end else begin
            lead_q <= lead_q - LEAD_W'(1);
          end
        end
        ST_SHIFT: if (tick_i) begin
          if (last_edge) state_q <= ST_TRAIL;
          else           edge_q  <= edge_q + EDGE_W'(1);
        end
        ST_TRAIL: if (tick_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sclk_q <= 1'b0;
    else if (state_q == ST_IDLE) sclk_q <= cpol_live_i;
    else if (edge_go)            sclk_q <= ~sclk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cs_q <= 1'b1;
    else if (state_q == ST_IDLE) cs_q <= start_i ? cs_pol_live_i : ~cs_pol_live_i;
    else if (finish_o)           cs_q <= ~cs_pol_q_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= finish_o;
  end
endmodule

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl #(
  parameter int MAX_LEN = 32,
  parameter int DIV_W   = 8,
  parameter int DLY_W   = 2,
  localparam int LEN_W  = $clog2(MAX_LEN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic               cs_pol_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [LEN_W-1:0]   len_m1_i,
  input  logic [DLY_W-1:0]   dly_i,
  input  logic [MAX_LEN-1:0] tx_data_i,
  input  logic               miso_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [MAX_LEN-1:0] rx_data_o,
  output logic               sclk_o,
  output logic               cs_o,
  output logic               mosi_o
);
  logic               cfg_cpha_q;
  logic               cfg_cs_pol_q;
  logic [LEN_W-1:0]   cfg_len_m1_q;
  logic [DIV_W-1:0]   cfg_half_m1_q;
  logic [MAX_LEN-1:0] rx_q;
  logic [MAX_LEN-1:0] rx_sr;
  logic               load, tick, shift, sample, finish;

  // clamp keeps the serial period at 4 system clocks or more
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_cpha_q    <= 1'b0;
      cfg_cs_pol_q  <= 1'b0;
      cfg_len_m1_q  <= '0;
      cfg_half_m1_q <= DIV_W'(1);
    end else if (load) begin
      cfg_cpha_q    <= cpha_i;
      cfg_cs_pol_q  <= cs_pol_i;
      cfg_len_m1_q  <= len_m1_i;
      cfg_half_m1_q <= (div_i == '0) ? DIV_W'(1) : div_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rx_q <= '0;
    else if (finish) rx_q <= rx_sr;
  end

  assign rx_data_o = rx_q;

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy_o),
    .half_m1_i (cfg_half_m1_q),
    .tick_o    (tick)
  );

  spi_seq_fsm #(.LEN_W(LEN_W), .DLY_W(DLY_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .tick_i        (tick),
    .cpol_live_i   (cpol_i),
    .cs_pol_live_i (cs_pol_i),
    .dly_live_i    (dly_i),
    .cpha_q_i      (cfg_cpha_q),
    .cs_pol_q_i    (cfg_cs_pol_q),
    .len_m1_q_i    (cfg_len_m1_q),
    .busy_o        (busy_o),
    .load_o        (load),
    .shift_o       (shift),
    .sample_o      (sample),
    .finish_o      (finish),
    .done_o        (done_o),
    .sclk_o        (sclk_o),
    .cs_o          (cs_o)
  );

  spi_shift_unit #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .tx_i     (tx_data_i),
    .len_m1_i (len_m1_i),
    .shift_i  (shift),
    .sample_i (sample),
    .miso_i   (miso_i),
    .mosi_o   (mosi_o),
    .rx_o     (rx_sr)
  );
endmodule

// File: rtl/spi_master_ctrl_chk.sv
module spi_master_ctrl_chk #(
  parameter int LEN_W = 5,
  parameter int DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             done_o,
  input logic             cs_o,
  input logic             sclk_o,
  input logic             cfg_cpha_q,
  input logic             cfg_cs_pol_q,
  input logic [LEN_W-1:0] cfg_len_m1_q,
  input logic [DIV_W-1:0] cfg_half_m1_q
);
  a_r5_cs_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cs_o == cfg_cs_pol_q));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && (cs_o != cfg_cs_pol_q)));

  a_r8_busy_fall_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r10_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(cfg_len_m1_q) && $stable(cfg_half_m1_q)
                                   && $stable(cfg_cpha_q) && $stable(cfg_cs_pol_q)));

  a_r7_min_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && (sclk_o != $past(sclk_o))) |=> $stable(sclk_o));

  a_r7_half_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cfg_half_m1_q != '0));
endmodule

bind spi_master_ctrl spi_master_ctrl_chk #(.LEN_W(LEN_W), .DIV_W(DIV_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .cs_o          (cs_o),
  .sclk_o        (sclk_o),
  .cfg_cpha_q    (cfg_cpha_q),
  .cfg_cs_pol_q  (cfg_cs_pol_q),
  .cfg_len_m1_q  (cfg_len_m1_q),
  .cfg_half_m1_q (cfg_half_m1_q)
);

// File: tb/spi_master_ctrl_tb.sv
module spi_master_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        cpol_i = 1'b0, cpha_i = 1'b0, cs_pol_i = 1'b0;
  logic [7:0]  div_i = 8'd1;
  logic [4:0]  len_m1_i = 5'd7;
  logic [1:0]  dly_i = 2'd0;
  logic [31:0] tx_data_i = '0;
  logic        miso = 1'b0;
  logic        busy_o, done_o, sclk_o, cs_o, mosi_o;
  logic [31:0] rx_data_o;

  always #10 clk_i = ~clk_i;

  spi_master_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cpol_i(cpol_i),
    .cpha_i(cpha_i), .cs_pol_i(cs_pol_i), .div_i(div_i), .len_m1_i(len_m1_i),
    .dly_i(dly_i), .tx_data_i(tx_data_i), .miso_i(miso), .busy_o(busy_o),
    .done_o(done_o), .rx_data_o(rx_data_o), .sclk_o(sclk_o), .cs_o(cs_o),
    .mosi_o(mosi_o)
  );

  typedef struct packed {
    logic        cpol;
    logic        cpha;
    logic        cs_pol;
    logic [7:0]  div;
    logic [4:0]  len_m1;
    logic [1:0]  dly;
    logic [31:0] tx;
    logic [31:0] slv;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b0, 1'b0, 1'b0, 8'd0, 5'd7,  2'd0, 32'h0000_00A5, 32'h0000_003C},
    '{1'b0, 1'b1, 1'b0, 8'd1, 5'd7,  2'd1, 32'h0000_0096, 32'h0000_005A},
    '{1'b1, 1'b0, 1'b0, 8'd2, 5'd15, 2'd2, 32'h0000_BEEF, 32'h0000_1234},
    '{1'b1, 1'b1, 1'b0, 8'd3, 5'd31, 2'd3, 32'hDEAD_BEEF, 32'hCAFE_F00D},
    '{1'b0, 1'b0, 1'b1, 8'd1, 5'd0,  2'd0, 32'h0000_0001, 32'h0000_0001},
    '{1'b1, 1'b1, 1'b1, 8'd0, 5'd4,  2'd1, 32'hFFFF_FF15, 32'hFFFF_FF0A},
    '{1'b0, 1'b1, 1'b0, 8'd4, 5'd11, 2'd3, 32'h0000_0ABC, 32'hF0F0_F321},
    '{1'b1, 1'b0, 1'b1, 8'd1, 5'd30, 2'd0, 32'h1234_5678, 32'h89AB_CDEF}
  };

  int checks = 0, failures = 0, cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // bench-side slave and timing monitor
  vec_t  cur;
  logic  mon_en = 1'b0;
  logic  m_prev_act = 1'b0, m_prev_sclk = 1'b0, m_act, m_lead;
  int    m_cs, m_first, m_second, m_last, m_rel, m_edges, s_idx;
  logic [31:0] m_rx;

  function automatic logic slv_bit(input vec_t v, input int idx);
    int len;
    len = int'(v.len_m1) + 1;
    return (idx < len) ? v.slv[len-1-idx] : 1'b0;
  endfunction

  always @(negedge clk_i) begin
    m_act = mon_en && (cs_o == cur.cs_pol);
    if (m_act && !m_prev_act) begin
      m_cs = cyc; m_edges = 0; m_rx = '0; s_idx = 0;
      miso = slv_bit(cur, 0);
    end else if (m_act && (sclk_o != m_prev_sclk)) begin
      m_lead = (m_edges % 2 == 0);
      if (m_edges == 0) m_first = cyc;
      if (m_edges == 1) m_second = cyc;
      m_last = cyc;
      if (m_lead ^ cur.cpha) m_rx = {m_rx[30:0], mosi_o};
      else if (!(cur.cpha && m_edges == 0)) begin
        s_idx = s_idx + 1;
        miso = slv_bit(cur, s_idx);
      end
      m_edges = m_edges + 1;
    end
    if (!m_act && m_prev_act) m_rel = cyc;
    m_prev_act  = m_act;
    m_prev_sclk = sclk_o;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input bit disturb);
    int n, len;
    bit seen;
    logic [31:0] mask;
    n    = (v.div == 0) ? 1 : int'(v.div);
    len  = int'(v.len_m1) + 1;
    mask = (len == 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
    @(negedge clk_i);
    cpol_i = v.cpol; cpha_i = v.cpha; cs_pol_i = v.cs_pol; div_i = v.div;
    len_m1_i = v.len_m1; dly_i = v.dly; tx_data_i = v.tx; cur = v;
    repeat (2) @(negedge clk_i);
    chk(sclk_o == v.cpol, "R1 idle clock", 64'(sclk_o), 64'(v.cpol));
    chk(cs_o == !v.cs_pol, "R5 idle select", 64'(cs_o), 64'(!v.cs_pol));
    start_i = 1'b1; mon_en = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R9 busy after start", 64'(busy_o), 64'd1);
    if (disturb) begin
      repeat (6) @(negedge clk_i);
      tx_data_i = ~v.tx; len_m1_i = ~v.len_m1; div_i = 8'd0; dly_i = ~v.dly;
      cpha_i = ~v.cpha; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R9 start while busy", 64'(busy_o), 64'd1);
    end
    seen = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk_i);
      if (done_o) seen = 1;
    end
    chk(seen, "R8 done timeout", 64'(seen), 64'd1);
    chk(rx_data_o == (v.slv & mask), "R4 received word", 64'(rx_data_o), 64'(v.slv & mask));
    chk(busy_o == 1'b0, "R8 busy low at done", 64'(busy_o), 64'd0);
    chk(cs_o == !v.cs_pol, "R8 release at done", 64'(cs_o), 64'(!v.cs_pol));
    @(negedge clk_i);
    mon_en = 1'b0;
    chk(done_o == 1'b0, "R8 done single", 64'(done_o), 64'd0);
    chk(m_edges == 2 * len, "R3 edge count", 64'(m_edges), 64'(2 * len));
    chk(m_rx == (v.tx & mask), "R2 R3 sent bits", 64'(m_rx), 64'(v.tx & mask));
    chk(m_first - m_cs == (2 * int'(v.dly) + 1) * (n + 1), "R6 lead-in",
        64'(m_first - m_cs), 64'((2 * int'(v.dly) + 1) * (n + 1)));
    chk(m_second - m_first == n + 1, "R7 half period", 64'(m_second - m_first), 64'(n + 1));
    chk(m_rel - m_last == n + 1, "R8 trailing hold", 64'(m_rel - m_last), 64'(n + 1));
    chk(sclk_o == v.cpol, "R1 idle after", 64'(sclk_o), 64'(v.cpol));
    if (disturb)
      chk((m_rx == (v.tx & mask)) && (m_edges == 2 * len), "R10 settings frozen",
          64'(m_edges), 64'(2 * len));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0, "R8 reset flags", 64'({busy_o, done_o}), 64'd0);
    chk(cs_o == 1'b1, "R5 reset select", 64'(cs_o), 64'd1);
    chk(rx_data_o == '0, "R4 reset rx", 64'(rx_data_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(sclk_o == 1'b0, "R1 reset idle clock", 64'(sclk_o), 64'd0);
    for (int k = 0; k < 8; k++) run_vec(VECS[k], 1'b0);
    // second start and input changes during a transfer
    run_vec('{1'b0, 1'b0, 1'b0, 8'd2, 5'd7, 2'd1, 32'h0000_00C3, 32'h0000_0081}, 1'b1);
    run_vec('{1'b1, 1'b1, 1'b1, 8'd1, 5'd9, 2'd2, 32'h0000_02A7, 32'h0000_0155}, 1'b1);
    // nothing further starts after completion
    repeat (40) @(negedge clk_i);
    chk(busy_o == 1'b0, "R9 single completion", 64'(busy_o), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end
endmodule